// File: doc/BRIEF.md
# Register-Driven Single-Word Bus Bridge

This block lets a processor reach an external register bus without owning that bus itself. Software programs four 32-bit registers over a small register port: the target address, the data word, a timeout count and a control word. A control write that carries the start bit together with one direction bit makes the bridge carry out a single 32-bit read or write. The transfer runs on a request/acknowledge master port.

Progress is reported through a two-bit status field inside the control word. The codes are 0 Idle, 1 Busy, 2 Error and 3 Disabled. On a read, the word returned by the slave is placed in the data register. The address is checked against a parameterised window before any request is driven. A programmable cycle limit abandons a slave that never acknowledges.

Register select on `csr_sel`: 0 control, 1 address, 2 data, 3 timeout. Control word fields: bit 0 read request, bit 1 write request, bits 7:4 byte-lane mask, bits 13:12 status, bit 31 start.

Top module: `csr_bus_bridge`

## Requirements
- R1: After reset the status field reads 0 (Idle), the control, address and data registers read 0, and `m_req` is low.
- R2: Reading the control word returns the stored byte-lane mask in bits 7:4 and the status in bits 13:12. Bits 0, 1 and 31 always read 0, because the request bits clear themselves once a command is taken.
- R3: A control write with bit 31 set and exactly one of bit 0 (read) or bit 1 (write) set launches a transfer. `m_req` rises on the clock edge that captures the write. The status reads 1 (Busy) for as long as `m_req` is high.
- R4: A control write with bit 31 set and both or neither direction bits set gives status 2 (Error) and drives no request.
- R5: A start aimed at an address below `WIN_BASE` or above `WIN_LIMIT` (both inclusive bounds) gives status 2 and drives no request. A request never carries an address outside the window.
- R6: On a read, the acknowledged `m_rdata` word is loaded into the data register on the same edge that returns status to 0. With a slave that acknowledges in its Nth request cycle, `m_req` is high for N cycles.
- R7: A write drives `m_we`=1, `m_wdata` from the data register and `m_be` equal to the mask, where mask bit i enables byte i (bits 8i+7:8i). A read drives `m_we`=0 and `m_be`=4'hF.
- R8: With a nonzero timeout value T and no acknowledge, `m_req` stays high for exactly T cycles, then drops, and the status becomes 2. A timeout value of 0 lets a transfer wait without limit.
- R9: While `en` is low the status reads 3 (Disabled), `m_req` drops on the next edge and start commands launch nothing. One edge after `en` returns high, the status reads 0.
- R10: Every register write that arrives while the status is Busy is ignored.
- R11: A control write with bit 31 clear stores the mask and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable; low forces Disabled |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select (0 ctrl, 1 addr, 2 data, 3 timeout) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered read data of the selected register, one cycle after select |
| m_req | output | 1 | Master request, held until acknowledge or abort |
| m_we | output | 1 | Master direction, 1 = write |
| m_addr | output | 32 | Master address |
| m_wdata | output | 32 | Master write data |
| m_be | output | 4 | Master byte-lane enables |
| m_rdata | input | 32 | Slave read data, valid with acknowledge |
| m_ack | input | 1 | Slave acknowledge |

## Verification
A command's effects land on the edge that captures the control write. `m_req`, `m_we` and `m_be` are sampled on the next falling edge, and a rejected command is checked there for a low request. Register values appear on `csr_rdata` one edge after the select is set, so every register check sets the select on a falling edge and samples on the following one. Request length is counted in falling edges from the launch. The expected count is the slave latency plus one, or exactly the timeout value. Read data and the return to Idle are checked in the same readback after the request ends.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ERR  = 2'd2,
    ST_DIS  = 2'd3
  } bstat_t;

  localparam int CTL_RD     = 0;
  localparam int CTL_WR     = 1;
  localparam int CTL_BE_LSB = 4;
  localparam int CTL_ST_LSB = 12;
  localparam int CTL_INIT   = 31;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_TMO  = 2'd3;
endpackage

// File: rtl/bridge_win_chk.sv
module bridge_win_chk #(
  parameter int          AW    = 32,
  parameter logic [AW-1:0] LO  = 'h1000,
  parameter logic [AW-1:0] HI  = 'h1FFF
) (
  input  logic [AW-1:0] addr,
  output logic          in_win
);
  always_comb in_win = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/bridge_xfer.sv
module bridge_xfer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          launch,
  input  logic [TW-1:0] tmo,
  input  logic          m_ack,
  output logic          m_req,
  output logic          fin_ok,
  output logic          fin_tmo
);
  logic [TW-1:0] cnt_q;
  logic          tmo_on;

  assign tmo_on  = (tmo != '0);
  assign fin_ok  = m_req && m_ack;
  assign fin_tmo = m_req && !m_ack && tmo_on && (cnt_q == tmo - TW'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      m_req <= 1'b0;
      cnt_q <= '0;
    end else if (launch) begin
      m_req <= 1'b1;
      cnt_q <= '0;
    end else if (m_req) begin
      if (fin_ok || fin_tmo) m_req <= 1'b0;
      else                   cnt_q <= cnt_q + TW'(1);
    end
  end

  // R8
  tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && tmo_on) |-> (cnt_q < tmo));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack && !tmo_on && en) |=> m_req);
endmodule

// File: rtl/csr_bus_bridge.sv
module csr_bus_bridge
  import bridge_pkg::*;
#(
  parameter int          RW        = 32,
  parameter logic [RW-1:0] WIN_BASE = 'h0000_1000,
  parameter logic [RW-1:0] WIN_LIMIT = 'h0000_1FFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            csr_we,
  input  logic [1:0]      csr_sel,
  input  logic [RW-1:0]   csr_wdata,
  output logic [RW-1:0]   csr_rdata,
  output logic            m_req,
  output logic            m_we,
  output logic [RW-1:0]   m_addr,
  output logic [RW-1:0]   m_wdata,
  output logic [RW/8-1:0] m_be,
  input  logic [RW-1:0]   m_rdata,
  input  logic            m_ack
);
  localparam int BEW = RW / 8;

  bstat_t          st_q;
  logic [BEW-1:0]  mask_q;
  logic [RW-1:0]   addr_q, data_q, tmo_q;
  logic            dir_wr_q;
  logic            in_win, fin_ok, fin_tmo;
  logic            wr_ok, wr_c, start, dir_ok, launch;
  logic [RW-1:0]   ctl_rb;

  bridge_win_chk #(.AW(RW), .LO(WIN_BASE), .HI(WIN_LIMIT)) u_win (
    .addr   (addr_q),
    .in_win (in_win)
  );

  bridge_xfer #(.TW(RW)) u_xfer (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .launch  (launch),
    .tmo     (tmo_q),
    .m_ack   (m_ack),
    .m_req   (m_req),
    .fin_ok  (fin_ok),
    .fin_tmo (fin_tmo)
  );

  assign wr_ok  = (st_q != ST_BUSY);
  assign wr_c   = csr_we && (csr_sel == SEL_CTRL) && wr_ok;
  assign start  = wr_c && csr_wdata[CTL_INIT];
  assign dir_ok = csr_wdata[CTL_RD] ^ csr_wdata[CTL_WR];
  assign launch = start && en && (st_q != ST_DIS) && dir_ok && in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else if (!en) begin
      st_q <= ST_DIS;
    end else if (st_q == ST_DIS) begin
      st_q <= ST_IDLE;
    end else if (fin_ok) begin
      st_q <= ST_IDLE;
    end else if (fin_tmo) begin
      st_q <= ST_ERR;
    end else if (start) begin
      st_q <= launch ? ST_BUSY : ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      tmo_q    <= '0;
      dir_wr_q <= 1'b0;
    end else begin
      if (wr_c) mask_q <= csr_wdata[CTL_BE_LSB +: BEW];
      if (launch) dir_wr_q <= csr_wdata[CTL_WR];
      if (csr_we && wr_ok && csr_sel == SEL_ADDR) addr_q <= csr_wdata;
      if (csr_we && wr_ok && csr_sel == SEL_TMO)  tmo_q  <= csr_wdata;
      if (fin_ok && !dir_wr_q)                     data_q <= m_rdata;
      else if (csr_we && wr_ok && csr_sel == SEL_DATA) data_q <= csr_wdata;
    end
  end

  always_comb begin
    ctl_rb = '0;
    ctl_rb[CTL_BE_LSB +: BEW] = mask_q;
    ctl_rb[CTL_ST_LSB +: 2]   = st_q;
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else begin
      case (csr_sel)
        SEL_CTRL: csr_rdata <= ctl_rb;
        SEL_ADDR: csr_rdata <= addr_q;
        SEL_DATA: csr_rdata <= data_q;
        default:  csr_rdata <= tmo_q;
      endcase
    end
  end

  assign m_we    = dir_wr_q;
  assign m_addr  = addr_q;
  assign m_wdata = data_q;
  assign m_be    = dir_wr_q ? mask_q : '1;

  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    m_req |-> (st_q == ST_BUSY));

  // R5
  req_window_chk: assert property (@(posedge clk) disable iff (rst)
    m_req |-> (m_addr >= WIN_BASE && m_addr <= WIN_LIMIT));

  // R9
  en_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!m_req && st_q == ST_DIS));

  // R10
  busy_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BUSY && csr_we && csr_sel == SEL_CTRL) |=> $stable(mask_q));
endmodule

// File: tb/csr_bus_bridge_bench.sv
module csr_bus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst, en, csr_we;
  logic [1:0]  csr_sel;
  logic [31:0] csr_wdata, csr_rdata;
  logic        m_req, m_we, m_ack;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_be;

  int n_chk = 0;
  int n_fail = 0;

  // slave model
  logic [31:0] mem [16];
  int          lat = 0;
  logic        hang = 1'b0;
  int          wcnt;

  always #2 clk = ~clk;

  csr_bus_bridge u_csr_bus_bridge (
    .clk(clk), .rst(rst), .en(en), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be), .m_rdata(m_rdata), .m_ack(m_ack)
  );

  assign m_ack   = m_req && !hang && (wcnt == lat);
  assign m_rdata = mem[m_addr[5:2]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
    end else begin
      if (!m_req || m_ack) wcnt <= 0;
      else                 wcnt <= wcnt + 1;
      if (m_req && m_ack && m_we)
        for (int b = 0; b < 4; b++)
          if (m_be[b]) mem[m_addr[5:2]][b*8 +: 8] <= m_wdata[b*8 +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [31:0] val);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = val;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [1:0] sel, output logic [31:0] val);
    csr_sel = sel;
    @(negedge clk);
    val = csr_rdata;
  endtask

  task automatic count_req(output int n);
    n = 0;
    while (m_req && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    eq("R1 req", {31'b0, m_req}, 32'h0);
    csr_read(2'd0, v); eq("R1 ctrl", v, 32'h0);
    csr_read(2'd1, v); eq("R1 addr", v, 32'h0);
    csr_read(2'd2, v); eq("R1 data", v, 32'h0);
  endtask

  task automatic t_write_read();
    logic [31:0] v;
    int n;
    lat = 2;
    csr_write(2'd3, 32'h0);
    csr_write(2'd1, 32'h0000_1008);
    csr_write(2'd2, 32'hA5A5_1234);
    csr_write(2'd0, 32'h8000_00F2);
    eq("R3 req on launch", {31'b0, m_req}, 32'h1);
    eq("R7 we", {31'b0, m_we}, 32'h1);
    eq("R7 be full", {28'b0, m_be}, 32'hF);
    eq("R7 wdata", m_wdata, 32'hA5A5_1234);
    csr_read(2'd0, v); eq("R2 R3 busy readback", v, 32'h0000_10F0);
    count_req(n);
    csr_read(2'd0, v); eq("R3 idle after write", v, 32'h0000_00F0);
    csr_write(2'd2, 32'h0);
    csr_write(2'd0, 32'h8000_00F1);
    eq("R7 read we", {31'b0, m_we}, 32'h0);
    eq("R7 read be", {28'b0, m_be}, 32'hF);
    count_req(n); eq("R6 req length", n, lat + 1);
    csr_read(2'd2, v); eq("R6 read data", v, 32'hA5A5_1234);
    csr_read(2'd0, v); eq("R6 idle", v, 32'h0000_00F0);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    int n;
    lat = 1;
    csr_write(2'd2, 32'hFFFF_FFFF);
    csr_write(2'd0, 32'h8000_0052);
    eq("R7 partial be", {28'b0, m_be}, 32'h5);
    count_req(n);
    csr_write(2'd0, 32'h8000_0001);
    count_req(n);
    csr_read(2'd2, v); eq("R7 lane merge", v, 32'hA5FF_12FF);
  endtask

  task automatic t_window();
    logic [31:0] v;
    int n;
    csr_write(2'd1, 32'h0000_0FFC);
    csr_write(2'd0, 32'h8000_00F1);
    eq("R5 no req low", {31'b0, m_req}, 32'h0);
    csr_read(2'd0, v); eq("R5 err low", v[13:12], 32'h2);
    csr_write(2'd1, 32'h0000_2000);
    csr_write(2'd0, 32'h8000_00F1);
    eq("R5 no req high", {31'b0, m_req}, 32'h0);
    csr_read(2'd0, v); eq("R5 err high", v[13:12], 32'h2);
    csr_write(2'd1, 32'h0000_1FFC);
    csr_write(2'd0, 32'h8000_00F1);
    eq("R5 edge accepted", {31'b0, m_req}, 32'h1);
    count_req(n);
    csr_read(2'd0, v); eq("R5 edge idle", v[13:12], 32'h0);
  endtask

  task automatic t_baddir();
    logic [31:0] v;
    csr_write(2'd1, 32'h0000_1000);
    csr_write(2'd0, 32'h8000_00F3);
    eq("R4 both no req", {31'b0, m_req}, 32'h0);
    csr_read(2'd0, v); eq("R4 both err", v[13:12], 32'h2);
    csr_write(2'd0, 32'h0000_0000);
    csr_write(2'd0, 32'h8000_00F0);
    eq("R4 none no req", {31'b0, m_req}, 32'h0);
    csr_read(2'd0, v); eq("R4 none err", v[13:12], 32'h2);
  endtask

  task automatic t_nocmd();
    logic [31:0] v;
    csr_write(2'd0, 32'h0000_0031);
    eq("R11 no req", {31'b0, m_req}, 32'h0);
    csr_read(2'd0, v); eq("R11 mask kept status", v, 32'h0000_2030);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    int n;
    hang = 1'b1;
    csr_write(2'd3, 32'd5);
    csr_write(2'd0, 32'h8000_00F1);
    count_req(n); eq("R8 timeout length", n, 5);
    csr_read(2'd0, v); eq("R8 timeout err", v[13:12], 32'h2);
    hang = 1'b0; lat = 20;
    csr_write(2'd3, 32'd0);
    csr_write(2'd0, 32'h8000_00F1);
    count_req(n); eq("R8 zero disables", n, 21);
    csr_read(2'd0, v); eq("R8 zero idle", v[13:12], 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int n;
    lat = 8;
    csr_write(2'd1, 32'h0000_1010);
    csr_write(2'd2, 32'h1111_2222);
    csr_write(2'd0, 32'h8000_00F2);
    csr_write(2'd0, 32'h8000_0031);
    csr_write(2'd1, 32'h0000_1014);
    csr_write(2'd2, 32'h3333_4444);
    count_req(n);
    csr_read(2'd1, v); eq("R10 addr kept", v, 32'h0000_1010);
    csr_read(2'd2, v); eq("R10 data kept", v, 32'h1111_2222);
    csr_read(2'd0, v); eq("R10 ctrl kept", v, 32'h0000_00F0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    en = 1'b0;
    @(negedge clk);
    csr_read(2'd0, v); eq("R9 disabled", v[13:12], 32'h3);
    csr_write(2'd0, 32'h8000_00F1);
    eq("R9 start ignored", {31'b0, m_req}, 32'h0);
    csr_read(2'd0, v); eq("R9 still disabled", v[13:12], 32'h3);
    en = 1'b1;
    @(negedge clk);
    csr_read(2'd0, v); eq("R9 back idle", v[13:12], 32'h0);
    lat = 20;
    csr_write(2'd0, 32'h8000_00F1);
    eq("R9 launched", {31'b0, m_req}, 32'h1);
    en = 1'b0;
    @(negedge clk);
    eq("R9 abort req", {31'b0, m_req}, 32'h0);
    en = 1'b1;
    @(negedge clk);
    csr_read(2'd0, v); eq("R9 idle after abort", v[13:12], 32'h0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b1; csr_we = 1'b0; csr_sel = 2'd0; csr_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_partial();
    t_window();
    t_baddir();
    t_nocmd();
    t_timeout();
    t_busy_ignore();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule